// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the processor-facing side of a tile-based video engine. The host CPU reaches it through a 3-bit register select, an active-low select strobe, a read/write line and separate 8-bit write and read buses. Every cycle in which the select strobe is low is one register access. The select is decoded outside the block, so the eight registers repeat across the host window 0x2000 to 0x3FFF.

The port holds the control byte and the render-mask byte. It also holds the 15-bit temporary VRAM address, the 3-bit fine horizontal scroll and the current VRAM address. The scroll and address registers share one two-write phase toggle. A one-byte buffer delays VRAM reads, and the block keeps a vertical-blank flag and an even/odd frame bit.

A frame-end pulse input stands in for the video timing. After reset, the control, mask, scroll, toggle and read-buffer state stays at zero and ignores writes until the first frame-end pulse. A control bit chooses the direction of a 4-bit external palette-index port. In drive mode the port carries the renderer's index. In sample mode it is captured as a background colour selector. An active-low interrupt output feeds the host NMI input.

Top module: `vp_cpu_port`

## Requirements
- R1: An access takes place only in a cycle with `cs_n` low. Writes to register 0 (control) and register 1 (mask) appear on `ctrl_q` and `mask_q` after that clock edge. With `cs_n` high, nothing changes.
- R2: While `rst_n` is low, the following are cleared: control, mask, temporary address, fine-X, toggle, read buffer, VRAM address, vertical-blank flag, odd-frame bit and port enable. `nmi_n` reads 1.
- R3: From reset until the first `frame_end` pulse after it, control, mask, temporary address, fine-X, toggle and read buffer stay zero. Writes to registers 0, 1, 5 and 6 are ignored, and data-register reads return 0. A write made in the same cycle as that pulse is also ignored.
- R4: Register 5 is the scroll register. A write with the toggle at 0 sets temp[4:0] = d[7:3] and fine-X = d[2:0]. A write with the toggle at 1 sets temp[9:5] = d[7:3] and temp[14:12] = d[2:0]. Each write flips the toggle.
- R5: Register 6 is the address register. A write with the toggle at 0 sets temp[13:8] = d[5:0] and temp[14] = 0. A write with the toggle at 1 sets temp[7:0] = d and copies the new temp into the VRAM address. Each write flips the toggle.
- R6: A control write copies d[1:0] into temp[11:10].
- R7: A read of register 2 (status) returns {vblank, 7'b0}. It clears the vertical-blank flag and the toggle. `frame_end` sets the flag, and this wins over a status read in the same cycle.
- R8: A read of register 7 (data) returns the buffered byte and loads the buffer from `vram_rdata`. A write of register 7 raises `vram_we` in that cycle, with `vram_wdata` equal to the written byte. Both kinds of access add 1 to the VRAM address, or 32 when control bit 2 is set.
- R9: `nmi_n` is low exactly while the vertical-blank flag and control bit 7 are both set.
- R10: With control bit 6 set, `ext_oe` is 1, `ext_out` equals `pix_idx` and `bg_idx` reads 0. With the bit clear, `ext_oe` is 0, `ext_out` is 0 and `bg_idx` carries `ext_in` registered one cycle. `ext_oe` is never 1 while the bit is clear.
- R11: Each `frame_end` pulse inverts `odd_frame`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low register select |
| rw | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 3 | Register number |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| vram_rdata | input | 8 | Byte at the current VRAM address |
| vram_addr | output | 15 | Current VRAM address |
| vram_we | output | 1 | VRAM write strobe |
| vram_wdata | output | 8 | VRAM write byte |
| ctrl_q | output | 8 | Control register |
| mask_q | output | 8 | Mask register |
| tmp_addr | output | 15 | Temporary VRAM address |
| fine_x | output | 3 | Fine horizontal scroll |
| odd_frame | output | 1 | Even/odd frame bit |
| nmi_n | output | 1 | Active-low interrupt to host NMI |
| pix_idx | input | IDX_W | Renderer palette index |
| ext_in | input | IDX_W | External index port, input side |
| ext_out | output | IDX_W | External index port, output side |
| ext_oe | output | 1 | External port drive enable |
| bg_idx | output | IDX_W | Sampled background selector |

## Verification
Scroll and address writes are driven with different bit patterns in both toggle phases. This separates the field placements from one another and from the two-bit nametable copy. A status read placed between two address writes shows that the toggle is shared and that the read clears it.

Data reads with changing `vram_rdata` separate the buffered return value from the value just fetched. Repeating the access with control bit 2 set separates the +1 step from the +32 step.

Writes made during the post-reset hold are compared with the same writes made after the frame pulse. A status read that coincides with `frame_end` shows which of the two takes priority.

// File: rtl/vp_cpu_port.sv
module vp_cpu_port #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rw,
  input  logic [2:0]       reg_sel,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  input  logic             frame_end,
  input  logic [7:0]       vram_rdata,
  output logic [14:0]      vram_addr,
  output logic             vram_we,
  output logic [7:0]       vram_wdata,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       mask_q,
  output logic [14:0]      tmp_addr,
  output logic [2:0]       fine_x,
  output logic             odd_frame,
  output logic             nmi_n,
  input  logic [IDX_W-1:0] pix_idx,
  input  logic [IDX_W-1:0] ext_in,
  output logic [IDX_W-1:0] ext_out,
  output logic             ext_oe,
  output logic [IDX_W-1:0] bg_idx
);

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_MASK = 3'd1;
  localparam logic [2:0] SEL_STAT = 3'd2;
  localparam logic [2:0] SEL_SCRL = 3'd5;
  localparam logic [2:0] SEL_ADDR = 3'd6;
  localparam logic [2:0] SEL_DATA = 3'd7;

  logic [7:0]       ctrl_r, mask_r, buf_r, ctrl_d;
  logic [14:0]      t_r, v_r, t_d, v_d;
  logic [2:0]       fx_r, fx_d;
  logic             wt_r, wt_d, vbl_r, odd_r, hold_r, oe_r;
  logic [IDX_W-1:0] bg_r;

  wire acc     = !cs_n;
  wire wr      = acc && !rw;
  wire rd      = acc && rw;
  wire open_w  = wr && !hold_r;
  wire wr_ctrl = open_w && reg_sel == SEL_CTRL;
  wire wr_mask = open_w && reg_sel == SEL_MASK;
  wire wr_scrl = open_w && reg_sel == SEL_SCRL;
  wire wr_addr = open_w && reg_sel == SEL_ADDR;
  wire wr_data = wr && reg_sel == SEL_DATA;
  wire rd_stat = rd && reg_sel == SEL_STAT;
  wire rd_data = rd && reg_sel == SEL_DATA;

  assign ctrl_d = wr_ctrl ? cpu_wdata : ctrl_r;

  always_comb begin
    t_d  = t_r;
    fx_d = fx_r;
    wt_d = wt_r;
    if (wr_ctrl) t_d[11:10] = cpu_wdata[1:0];
    if (wr_scrl) begin
      if (!wt_r) begin
        t_d[4:0] = cpu_wdata[7:3];
        fx_d     = cpu_wdata[2:0];
      end else begin
        t_d[9:5]   = cpu_wdata[7:3];
        t_d[14:12] = cpu_wdata[2:0];
      end
      wt_d = !wt_r;
    end
    if (wr_addr) begin
      if (!wt_r) begin
        t_d[13:8] = cpu_wdata[5:0];
        t_d[14]   = 1'b0;
      end else begin
        t_d[7:0] = cpu_wdata;
      end
      wt_d = !wt_r;
    end
    if (rd_stat) wt_d = 1'b0;
  end

  always_comb begin
    v_d = v_r;
    if (wr_addr && wt_r)
      v_d = t_d;
    else if (rd_data || wr_data)
      v_d = v_r + (ctrl_r[2] ? 15'd32 : 15'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      mask_r <= '0;
      t_r    <= '0;
      fx_r   <= '0;
      wt_r   <= 1'b0;
      buf_r  <= '0;
      v_r    <= '0;
      vbl_r  <= 1'b0;
      odd_r  <= 1'b0;
      hold_r <= 1'b1;
      oe_r   <= 1'b0;
      bg_r   <= '0;
    end else begin
      ctrl_r <= ctrl_d;
      if (wr_mask) mask_r <= cpu_wdata;
      t_r  <= t_d;
      fx_r <= fx_d;
      wt_r <= wt_d;
      v_r  <= v_d;
      if (rd_data && !hold_r) buf_r <= vram_rdata;
      if (frame_end)    vbl_r <= 1'b1;
      else if (rd_stat) vbl_r <= 1'b0;
      if (frame_end) begin
        odd_r  <= !odd_r;
        hold_r <= 1'b0;
      end
      oe_r <= ctrl_d[6];
      bg_r <= oe_r ? '0 : ext_in;
    end
  end

  always_comb begin
    cpu_rdata = 8'h00;
    if (rd_stat)      cpu_rdata = {vbl_r, 7'b0};
    else if (rd_data) cpu_rdata = buf_r;
  end

  assign vram_we    = wr_data;
  assign vram_wdata = cpu_wdata;
  assign vram_addr  = v_r;
  assign ctrl_q     = ctrl_r;
  assign mask_q     = mask_r;
  assign tmp_addr   = t_r;
  assign fine_x     = fx_r;
  assign odd_frame  = odd_r;
  assign nmi_n      = !(vbl_r && ctrl_r[7]);
  assign ext_oe     = oe_r;
  assign ext_out    = oe_r ? pix_idx : '0;
  assign bg_idx     = bg_r;

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold_r |-> (ctrl_r == 0 && mask_r == 0 && t_r == 0 && fx_r == 0 && !wt_r && buf_r == 0)); // R3
  AST_HOLD_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !hold_r); // R3
  AST_VBL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> vbl_r); // R7
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !frame_end) |=> (!vbl_r && !wt_r)); // R7
  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && reg_sel == SEL_DATA) |=>
      (v_r == $past(v_r) + ($past(ctrl_r[2]) ? 15'd32 : 15'd1))); // R8
  AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_n |-> vbl_r); // R9
  AST_PORT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_r[6] |-> !oe_r); // R10
  AST_ODD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> odd_r != $past(odd_r)); // R11

endmodule

// File: tb/sim_vp_cpu_port.sv
module sim_vp_cpu_port;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rw = 1'b1, frame_end = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] cpu_wdata = '0, vram_rdata = '0;
  logic [3:0] pix_idx = '0, ext_in = '0;
  logic [7:0] cpu_rdata, vram_wdata, ctrl_q, mask_q;
  logic [14:0] vram_addr, tmp_addr;
  logic [2:0] fine_x;
  logic vram_we, odd_frame, nmi_n, ext_oe;
  logic [3:0] ext_out, bg_idx;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vp_cpu_port u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); cs_n = 0; rw = 0; reg_sel = a; cpu_wdata = d;
    @(negedge clk); cs_n = 1; rw = 1;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rw = 1; reg_sel = a;
    #1 d = cpu_rdata;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic frame();
    @(negedge clk); frame_end = 1;
    @(negedge clk); frame_end = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R2 ctrl", ctrl_q, 0);  check("R2 mask", mask_q, 0);
    check("R2 temp", tmp_addr, 0); check("R2 finex", fine_x, 0);
    check("R2 vaddr", vram_addr, 0); check("R2 nmi", nmi_n, 1);
    check("R2 oe", ext_oe, 0); check("R2 odd", odd_frame, 0);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    wr(0, 8'hFF); wr(1, 8'h1E); wr(5, 8'hFF);
    check("R3 ctrl held", ctrl_q, 0); check("R3 mask held", mask_q, 0);
    check("R3 temp held", tmp_addr, 0); check("R3 finex held", fine_x, 0);
    vram_rdata = 8'hAB;
    rd(7, d); check("R3 buf read", d, 0);
    rd(7, d); check("R3 buf still zero", d, 0);
    @(negedge clk); frame_end = 1; cs_n = 0; rw = 0; reg_sel = 1; cpu_wdata = 8'h77;
    @(negedge clk); frame_end = 0; cs_n = 1; rw = 1;
    check("R3 write at frame edge", mask_q, 0);
    check("R11 odd after frame", odd_frame, 1);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    rd(2, d); check("R7 vblank read", d, 8'h80);
    rd(2, d); check("R7 vblank cleared", d, 8'h00);
    @(negedge clk); cs_n = 1; rw = 0; reg_sel = 0; cpu_wdata = 8'h55;
    @(negedge clk); rw = 1;
    check("R1 no select", ctrl_q, 0);
    wr(1, 8'h1E); check("R1 mask write", mask_q, 8'h1E);
    wr(0, 8'h03); check("R6 nametable", tmp_addr, 15'h0C00);
  endtask

  task automatic t_scroll_addr();
    logic [7:0] d;
    rd(2, d);
    wr(5, 8'h7D); check("R4 first temp", tmp_addr, 15'h0C0F); check("R4 finex", fine_x, 5);
    wr(5, 8'h5E); check("R4 second temp", tmp_addr, 15'h6D6F);
    wr(6, 8'h3F); check("R5 high byte", tmp_addr, 15'h3F6F);
    wr(6, 8'h10); check("R5 low byte", tmp_addr, 15'h3F10); check("R5 copy", vram_addr, 15'h3F10);
    wr(6, 8'h21); rd(2, d); wr(6, 8'h22);
    check("R7 toggle reset", tmp_addr, 15'h2210); check("R7 vaddr kept", vram_addr, 15'h3F10);
  endtask

  task automatic t_data();
    logic [7:0] d;
    vram_rdata = 8'h5A; rd(7, d); check("R8 first read", d, 0);
    check("R8 inc1", vram_addr, 15'h3F11);
    vram_rdata = 8'hC3; rd(7, d); check("R8 buffered", d, 8'h5A);
    check("R8 inc1 again", vram_addr, 15'h3F12);
    wr(0, 8'h04);
    @(negedge clk); cs_n = 0; rw = 0; reg_sel = 7; cpu_wdata = 8'h99;
    #1 check("R8 we", vram_we, 1); check("R8 wdata", vram_wdata, 8'h99);
    @(negedge clk); cs_n = 1; rw = 1;
    check("R8 inc32", vram_addr, 15'h3F32);
  endtask

  task automatic t_nmi();
    logic [7:0] d;
    wr(0, 8'h80); check("R9 idle", nmi_n, 1);
    frame(); check("R9 asserted", nmi_n, 0);
    rd(2, d); check("R9 released", nmi_n, 1);
    @(negedge clk); frame_end = 1; cs_n = 0; rw = 1; reg_sel = 2;
    @(negedge clk); frame_end = 0; cs_n = 1;
    rd(2, d); check("R7 set wins", d, 8'h80);
    check("R11 odd toggles", odd_frame, 1);
  endtask

  task automatic t_port();
    pix_idx = 4'hA; ext_in = 4'h6;
    wr(0, 8'h40); check("R10 oe on", ext_oe, 1); check("R10 drive", ext_out, 4'hA);
    @(negedge clk); check("R10 bg zero", bg_idx, 0);
    wr(0, 8'h00); check("R10 oe off", ext_oe, 0); check("R10 out zero", ext_out, 0);
    @(negedge clk); check("R10 sampled", bg_idx, 4'h6);
  endtask

  task automatic t_rereset();
    do_reset();
    check("R2 ctrl again", ctrl_q, 0); check("R2 temp again", tmp_addr, 0);
    wr(0, 8'h80); check("R3 ignored again", ctrl_q, 0);
    frame(); wr(0, 8'h80); check("R3 open after frame", ctrl_q, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_hold();
    t_decode();
    t_scroll_addr();
    t_data();
    t_nmi();
    t_port();
    t_rereset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule